// File: doc/BRIEF.md
# Dual Halfword Multiply-Subtract-Accumulate Unit

This execution unit handles a single instruction that forms two signed 16×16 products from the halfwords of two 32-bit operands. It adds the difference of those products to a 32-bit accumulate value. The unit accepts either of two 32-bit encodings of the instruction:

- a compact form that always executes;
- a conditional form that carries a 4-bit condition field and executes only when an externally evaluated pass signal is high.

The unit decodes the register indices from the instruction word and presents them combinationally, so a surrounding register file can supply the three operand values. One clock later it returns the destination index, the 32-bit result, a write enable and the updated sticky saturation flag.

An instruction bit selects whether the two halfwords of the second operand are exchanged before multiplying. Overflow is detected only in the final accumulate. It sets the sticky flag, but the result is not clamped: the low 32 bits of the exact sum are written. The flag is only ever set here and never cleared. A word that matches neither encoding is reported as undefined and writes nothing.

Top module: `dmsa_unit`

## Requirements
- R1: A compact word has bits [31:20] = 0xFB4 and bits [7:5] = 000. Its fields are: first source n in [19:16], accumulate source a in [15:12], destination d in [11:8], exchange flag in bit 4, and second source m in [3:0]. `src_n_idx`, `src_a_idx` and `src_m_idx` show n, a and m in the same cycle. `rd_idx` shows d with the result.
- R2: A conditional word has bits [27:20] = 0x70, bits [7:6] = 01 and bit 4 = 1. Its fields are: condition in [31:28], destination d in [19:16], accumulate source a in [15:12], second source m in [11:8], exchange flag in bit 5, and first source n in [3:0].
- R3: With the exchange flag at 0, the result is a + n[15:0]×m[15:0] − n[31:16]×m[31:16], with all halfwords taken as signed.
- R4: With the exchange flag at 1, the result is a + n[15:0]×m[31:16] − n[31:16]×m[15:0].
- R5: The written result is the low 32 bits of the exact sum. It wraps and is never saturated.
- R6: `q_out` equals `q_in` OR (an executed instruction whose exact sum lies outside the signed 32-bit range). The flag is never cleared.
- R7: A conditional word with `cond_pass` low writes nothing, and `q_out` equals `q_in`.
- R8: A valid word matching neither encoding raises `undef`, writes nothing, and leaves `q_out` equal to `q_in`.
- R9: `out_valid` follows `in_valid` one clock later. `wr_en` is only high together with `out_valid`.
- R10: While `rst` is high, `out_valid`, `wr_en`, `undef` and `q_out` are all low, whatever `q_in` is.
- R11: A compact word executes regardless of `cond_pass`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| rn_val | input | 32 | Value of the first source register |
| rm_val | input | 32 | Value of the second source register |
| ra_val | input | 32 | Value of the accumulate register |
| q_in | input | 1 | Current sticky saturation flag |
| cond_pass | input | 1 | Condition field of a conditional word passed |
| src_n_idx | output | 4 | Decoded first source index (combinational) |
| src_m_idx | output | 4 | Decoded second source index (combinational) |
| src_a_idx | output | 4 | Decoded accumulate source index (combinational) |
| out_valid | output | 1 | Registered result slot is valid |
| wr_en | output | 1 | Write the result to the destination |
| rd_idx | output | 4 | Destination register index |
| result | output | 32 | Accumulated result, wrapped to 32 bits |
| q_out | output | 1 | Updated sticky saturation flag |
| undef | output | 1 | Word matched neither encoding |

## Verification
The bench builds the unit with its default 32-bit word, so the halfwords are 16 bits wide. This makes the extreme products reachable by direct stimulus. −32768 squared gives the largest product, and pairing it with an accumulator at 0x7FFFFFFF or 0x80000000 pushes the exact sum just past either end of the signed range. The same width lets random operands, biased toward these extremes, cover both exchange settings, both encodings, failing conditions and malformed words, all against a reference computed with 64-bit integers.

// File: rtl/dmsa_pkg.sv
package dmsa_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int IDX_W  = 4;

    // fixed opcode bits of each encoding
    localparam logic [11:0] CMP_OPC = 12'hFB4;
    localparam logic [7:0]  CND_OPC = 8'h70;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_CMP  = 2'd1,
        FORM_CND  = 2'd2
    } form_e;

    typedef struct packed {
        form_e            form;
        logic             xchg;
        logic [IDX_W-1:0] n_idx;
        logic [IDX_W-1:0] m_idx;
        logic [IDX_W-1:0] a_idx;
        logic [IDX_W-1:0] d_idx;
    } dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] sum;
        logic              ovf;
    } acc_t;

    // true when the top three bits of a two-bit-extended sum agree
    function automatic logic fits_word(input logic [WORD_W+1:0] s);
        return (s[WORD_W+1:WORD_W-1] == 3'b000) || (s[WORD_W+1:WORD_W-1] == 3'b111);
    endfunction
endpackage

// File: rtl/dmsa_hmul.sv
module dmsa_hmul #(
    parameter int HW = 16
) (
    input  logic [HW-1:0]          a,
    input  logic [HW-1:0]          b,
    output logic signed [2*HW-1:0] p
);
    assign p = $signed(a) * $signed(b);
endmodule

// File: rtl/dmsa_mac.sv
module dmsa_mac
    import dmsa_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic [W-1:0] rn,
    input  logic [W-1:0] rm,
    input  logic [W-1:0] ra,
    input  logic         xchg,
    output acc_t         acc
);
    localparam int HW = W / 2;
    localparam int PW = 2 * HW;
    localparam int DW = PW + 1;
    localparam int SW = W + 2;

    logic [HW-1:0]        op_n [2];
    logic [HW-1:0]        op_m [2];
    logic signed [PW-1:0] prod [2];
    logic [DW-1:0]        diff;
    logic [SW-1:0]        total;

    assign op_n[0] = rn[HW-1:0];
    assign op_n[1] = rn[W-1:HW];
    assign op_m[0] = xchg ? rm[W-1:HW] : rm[HW-1:0];
    assign op_m[1] = xchg ? rm[HW-1:0] : rm[W-1:HW];

    for (genvar g = 0; g < 2; g++) begin : g_mul
        dmsa_hmul #(.HW(HW)) u_mul (
            .a (op_n[g]),
            .b (op_m[g]),
            .p (prod[g])
        );
    end

    // one extra bit keeps the product difference exact
    assign diff  = {prod[0][PW-1], prod[0]} - {prod[1][PW-1], prod[1]};
    assign total = {{(SW-W){ra[W-1]}}, ra} + {{(SW-DW){diff[DW-1]}}, diff};

    always_comb begin
        acc.sum = total[W-1:0];
        acc.ovf = !fits_word(total);
    end
endmodule

// File: rtl/dmsa_decode.sv
module dmsa_decode
    import dmsa_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_t              dec
);
    logic is_cmp;
    logic is_cnd;

    assign is_cmp = (instr[31:20] == CMP_OPC) && (instr[7:5] == 3'b000);
    assign is_cnd = (instr[27:20] == CND_OPC) && (instr[7:6] == 2'b01) && instr[4];

    always_comb begin
        dec      = '0;
        dec.form = FORM_NONE;
        if (is_cmp) begin
            dec.form  = FORM_CMP;
            dec.n_idx = instr[19:16];
            dec.a_idx = instr[15:12];
            dec.d_idx = instr[11:8];
            dec.xchg  = instr[4];
            dec.m_idx = instr[3:0];
        end else if (is_cnd) begin
            dec.form  = FORM_CND;
            dec.d_idx = instr[19:16];
            dec.a_idx = instr[15:12];
            dec.m_idx = instr[11:8];
            dec.xchg  = instr[5];
            dec.n_idx = instr[3:0];
        end
    end
endmodule

// File: rtl/dmsa_unit.sv
module dmsa_unit
    import dmsa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] instr,
    input  logic [WORD_W-1:0] rn_val,
    input  logic [WORD_W-1:0] rm_val,
    input  logic [WORD_W-1:0] ra_val,
    input  logic              q_in,
    input  logic              cond_pass,
    output logic [IDX_W-1:0]  src_n_idx,
    output logic [IDX_W-1:0]  src_m_idx,
    output logic [IDX_W-1:0]  src_a_idx,
    output logic              out_valid,
    output logic              wr_en,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] result,
    output logic              q_out,
    output logic              undef
);
    dec_t dec;
    acc_t acc;
    logic exec;

    dmsa_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    dmsa_mac #(.W(WORD_W)) u_mac (
        .rn   (rn_val),
        .rm   (rm_val),
        .ra   (ra_val),
        .xchg (dec.xchg),
        .acc  (acc)
    );

    assign src_n_idx = dec.n_idx;
    assign src_m_idx = dec.m_idx;
    assign src_a_idx = dec.a_idx;

    assign exec = in_valid &&
                  ((dec.form == FORM_CMP) || ((dec.form == FORM_CND) && cond_pass));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            undef     <= 1'b0;
            q_out     <= 1'b0;
            rd_idx    <= '0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= exec;
            undef     <= in_valid && (dec.form == FORM_NONE);
            q_out     <= q_in | (exec & acc.ovf);
            if (exec) begin
                rd_idx <= dec.d_idx;
                result <= acc.sum;
            end
        end
    end
endmodule

// File: rtl/dmsa_unit_chk.sv
module dmsa_unit_chk
    import dmsa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [WORD_W-1:0] instr,
    input logic              q_in,
    input logic              cond_pass,
    input logic [IDX_W-1:0]  src_n_idx,
    input logic [IDX_W-1:0]  src_m_idx,
    input logic              out_valid,
    input logic              wr_en,
    input logic [IDX_W-1:0]  rd_idx,
    input logic              q_out,
    input logic              undef
);
    logic cmp_w;
    logic cnd_w;
    assign cmp_w = (instr[31:20] == CMP_OPC) && (instr[7:5] == 3'b000);
    assign cnd_w = (instr[27:20] == CND_OPC) && (instr[7:6] == 2'b01) && instr[4];

    // R10
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !wr_en && !undef && !q_out));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

    // R9
    write_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);

    // R8
    undef_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        undef |-> !wr_en);

    // R6
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(q_in)) |-> q_out);

    // R6
    set_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(q_in) && q_out) |-> wr_en);

    // R7
    cond_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(cnd_w) && !$past(cond_pass))
            |-> (!wr_en && (q_out == $past(q_in))));

    // R11
    compact_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(cmp_w)) |-> (wr_en && rd_idx == $past(instr[11:8])));

    // R2
    cond_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(in_valid) && $past(cnd_w) && $past(cond_pass))
            |-> (wr_en && rd_idx == $past(instr[19:16])));

    // R1
    cmp_src_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cmp_w) |-> (src_n_idx == instr[19:16] && src_m_idx == instr[3:0]));

    // R2
    cnd_src_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cnd_w) |-> (src_n_idx == instr[3:0] && src_m_idx == instr[11:8]));
endmodule

bind dmsa_unit dmsa_unit_chk u_chk (.*);

// File: tb/sim_dmsa_unit.sv
module sim_dmsa_unit;
    localparam int CLK_PERIOD = 10;
    localparam longint MAXP = 64'sd2147483647;
    localparam longint MINN = -64'sd2147483648;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rn_val = '0;
    logic [31:0] rm_val = '0;
    logic [31:0] ra_val = '0;
    logic        q_in = 1'b0;
    logic        cond_pass = 1'b0;
    logic [3:0]  src_n_idx, src_m_idx, src_a_idx, rd_idx;
    logic        out_valid, wr_en, q_out, undef;
    logic [31:0] result;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmsa_unit u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_cmp(input logic [3:0] n, a, d, m, input logic x);
        return {12'hFB4, n, a, d, 3'b000, x, m};
    endfunction

    function automatic logic [31:0] enc_cnd(input logic [3:0] c, d, a, m, n, input logic x);
        return {c, 8'h70, d, a, m, 2'b01, x, 1'b1, n};
    endfunction

    task automatic ref_model(input logic [31:0] w, rn, rm, ra, input logic qi, cp,
                             output logic bad, we, qo, output logic [3:0] d, n, m, a,
                             output logic [31:0] res);
        logic cmpf, cndf, x;
        longint nl, nh, ml, mh, s;
        cmpf = (w[31:20] == 12'hFB4) && (w[7:5] == 3'b000);
        cndf = (w[27:20] == 8'h70) && (w[7:6] == 2'b01) && w[4];
        bad = !cmpf && !cndf;
        d = 0; n = 0; m = 0; a = 0; x = 0;
        if (cmpf) begin n = w[19:16]; a = w[15:12]; d = w[11:8]; x = w[4]; m = w[3:0]; end
        if (cndf) begin d = w[19:16]; a = w[15:12]; m = w[11:8]; x = w[5]; n = w[3:0]; end
        we = cmpf || (cndf && cp);
        nl = longint'($signed(rn[15:0]));
        nh = longint'($signed(rn[31:16]));
        ml = longint'($signed(x ? rm[31:16] : rm[15:0]));
        mh = longint'($signed(x ? rm[15:0] : rm[31:16]));
        s  = longint'($signed(ra)) + nl * ml - nh * mh;
        res = s[31:0];
        qo = qi | (we && (s > MAXP || s < MINN));
    endtask

    task automatic run_op(input logic [31:0] w, rn, rm, ra, input logic qi, cp, input string tag);
        logic bad, we, qo;
        logic [3:0] d, n, m, a;
        logic [31:0] res;
        ref_model(w, rn, rm, ra, qi, cp, bad, we, qo, d, n, m, a, res);
        @(negedge clk);
        in_valid = 1'b1; instr = w; rn_val = rn; rm_val = rm; ra_val = ra;
        q_in = qi; cond_pass = cp;
        #1;
        if (!bad) begin
            chk(src_n_idx == n && src_m_idx == m && src_a_idx == a, {tag, " src idx"},
                {20'd0, src_n_idx, src_m_idx, src_a_idx}, {20'd0, n, m, a});
        end
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R9 out_valid", 32'(out_valid), 32'd1);
        chk(undef == bad, {tag, " undef"}, 32'(undef), 32'(bad));
        chk(wr_en == we, {tag, " wr_en"}, 32'(wr_en), 32'(we));
        chk(q_out == qo, {tag, " q_out"}, 32'(q_out), 32'(qo));
        if (we) begin
            chk(rd_idx == d, {tag, " rd_idx"}, 32'(rd_idx), 32'(d));
            chk(result == res, {tag, " result"}, result, res);
        end
    endtask

    function automatic logic [31:0] pick_val();
        logic [31:0] corner [7] = '{32'h80008000, 32'h7FFF7FFF, 32'h00008000,
                                    32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0};
        if ($urandom % 4 == 0) return corner[$urandom % 7];
        return $urandom;
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        q_in = 1'b1;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R10: quiet outputs under reset, even with q_in and in_valid high
        chk(!out_valid && !wr_en && !undef && !q_out, "R10 reset outputs",
            {28'd0, out_valid, wr_en, undef, q_out}, 32'd0);
        in_valid = 1'b0; q_in = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        // R9: idle cycle leaves no valid slot
        chk(!out_valid && !wr_en, "R9 idle", {30'd0, out_valid, wr_en}, 32'd0);

        // R3 plain products: 5*7 - 3*2 + 100 = 129
        run_op(enc_cmp(4'd1, 4'd2, 4'd3, 4'd4, 1'b0), 32'h00030005, 32'h00020007, 32'd100, 1'b0, 1'b1, "R3");
        // R4 exchanged: 5*2 - 3*7 + 100 = 89
        run_op(enc_cmp(4'd1, 4'd2, 4'd3, 4'd4, 1'b1), 32'h00030005, 32'h00020007, 32'd100, 1'b0, 1'b1, "R4");
        // R5 R6 positive overflow wraps to 0xBFFFFFFF and sets the flag
        run_op(enc_cmp(4'd5, 4'd6, 4'd7, 4'd8, 1'b0), 32'h00008000, 32'h80008000, 32'h7FFFFFFF, 1'b0, 1'b0, "R5");
        // R6 negative overflow wraps to 0x40000000
        run_op(enc_cmp(4'd9, 4'd10, 4'd11, 4'd12, 1'b0), 32'h80000000, 32'h80008000, 32'h80000000, 1'b0, 1'b1, "R6");
        // R6 both products at -32768 squared cancel; flag stays set from q_in
        run_op(enc_cmp(4'd0, 4'd1, 4'd2, 4'd3, 1'b1), 32'h80008000, 32'h80008000, 32'h7FFFFFFF, 1'b1, 1'b0, "R6");
        // R6 sum exactly at the upper limit, no overflow
        run_op(enc_cmp(4'd2, 4'd3, 4'd4, 4'd5, 1'b0), 32'h00008000, 32'h00008000, 32'h3FFFFFFF, 1'b0, 1'b0, "R6");
        // R4 exchanged overflow: n_lo * m_hi = 2^30
        run_op(enc_cmp(4'd2, 4'd3, 4'd4, 4'd5, 1'b1), 32'h00008000, 32'h80000000, 32'h40000000, 1'b0, 1'b0, "R4");
        // R2 conditional, passing
        run_op(enc_cnd(4'hA, 4'd13, 4'd14, 4'd15, 4'd6, 1'b1), 32'h00030005, 32'h00020007, 32'd7, 1'b0, 1'b1, "R2");
        // R7 conditional failing with overflowing operands
        run_op(enc_cnd(4'h0, 4'd1, 4'd2, 4'd3, 4'd4, 1'b0), 32'h00008000, 32'h80008000, 32'h7FFFFFFF, 1'b0, 1'b0, "R7");
        // R11 compact ignores cond_pass
        run_op(enc_cmp(4'd7, 4'd8, 4'd9, 4'd1, 1'b0), 32'h12345678, 32'h9ABCDEF0, 32'h0, 1'b0, 1'b0, "R11");
        // R8 malformed words
        run_op(32'h00000000, 32'h00008000, 32'h80008000, 32'h7FFFFFFF, 1'b0, 1'b1, "R8");
        run_op(enc_cmp(4'd1, 4'd2, 4'd3, 4'd4, 1'b0) | 32'h20, 32'h00008000, 32'h80008000, 32'h7FFFFFFF, 1'b1, 1'b1, "R8");
        run_op(enc_cnd(4'hE, 4'd1, 4'd2, 4'd3, 4'd4, 1'b0) & ~32'h10, 32'h1, 32'h1, 32'h1, 1'b0, 1'b1, "R8");
        // R1 all fields distinct
        run_op(enc_cmp(4'hC, 4'h5, 4'hA, 4'h3, 1'b0), 32'hFFFF0001, 32'h0001FFFF, 32'h00000010, 1'b0, 1'b1, "R1");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] w;
            int kind;
            kind = $urandom % 8;
            if (kind < 4)
                w = enc_cmp(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom));
            else if (kind < 7)
                w = enc_cnd(4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom));
            else
                w = $urandom;
            run_op(w, pick_val(), pick_val(), pick_val(), 1'($urandom), 1'($urandom), "random R3 R4 R6");
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule